// File: doc/BRIEF.md
# Boot-Block Sector Decoder and Lock Unit

This block sits beside the program/erase controller of a block-erasable flash array. It takes a 19-bit word address and finds which of 19 erase regions holds it. The region sizes are not uniform: one 8K-word boot region, two 4K-word parameter regions, one 16K-word region and fifteen 32K-word regions. An elaboration parameter chooses the layout. In the bottom-boot layout the small regions sit at the low end of the address space. In the top-boot layout the same sequence is mirrored to the high end. For the addressed region the block reports its index, its first word address and its length in words.

Each region has one lock bit. The block decides, cycle by cycle, whether a program or erase may touch the addressed region. That decision combines the region's lock bit, a write-protect pin and a three-level reset/power-down input. The controller uses the resulting grant flag to accept or refuse operations. Two requests act on the lock bits: a lock-set request and an erase request. Both take effect at the clock edge, and only when the grant flag is high. The addressed lock bit is also returned in a status byte.

Top module: `bb_sector_guard`

## Requirements
- R1: With TOP_BOOT=0, index 0 covers 0x00000–0x01FFF (8192 words), index 1 starts at 0x02000 and index 2 at 0x03000 (4096 words each), index 3 covers 0x04000–0x07FFF (16384 words), and index k from 4 to 18 starts at (k-3)*0x8000 (32768 words). blk_index, blk_base and blk_size reflect word_addr combinationally.
- R2: With TOP_BOOT=1, index k from 0 to 14 starts at k*0x8000 (32768 words), index 15 at 0x78000 (16384 words), index 16 at 0x7C000 and index 17 at 0x7D000 (4096 words each), and index 18 at 0x7E000 (8192 words).
- R3: A synchronous low rst_n sets every lock bit to 1 (unlocked). The rp_level input never alters the lock bits, including code 00.
- R4: rp_level codes 00 (power-down) and 11 (unused) hold modify_ok at 0 for every region.
- R5: rp_level code 10 (override) drives modify_ok to 1 whatever wp_pin and the lock bit are.
- R6: With rp_level code 01 (normal), modify_ok is 1 when wp_pin is 1. When wp_pin is 0, modify_ok equals the addressed region's lock bit, where 0 means locked.
- R7: lock_set_req with modify_ok=1 and erase_req=0 clears the addressed lock bit at the next clock edge. With modify_ok=0 the request leaves every lock bit unchanged.
- R8: erase_req with modify_ok=1 sets the addressed lock bit to 1 at the next clock edge, even when lock_set_req is also high. With modify_ok=0 the erase request leaves the bit unchanged.
- R9: status_byte carries the addressed region's lock bit on bit 6 (1 means unlocked). All its other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; unlocks all regions |
| word_addr | input | 19 | Word address to decode |
| rp_level | input | 2 | Reset pin level: 00 power-down, 01 normal, 10 override, 11 unused |
| wp_pin | input | 1 | Write-protect pin; 0 enforces lock bits |
| lock_set_req | input | 1 | Request to lock the addressed region |
| erase_req | input | 1 | Erase notice for the addressed region; unlocks it |
| blk_index | output | 5 | Region index, 0–18 in ascending address order |
| blk_base | output | 19 | First word address of the region |
| blk_size | output | 19 | Region length in words |
| modify_ok | output | 1 | Program/erase allowed for the addressed region |
| lock_bit | output | 1 | Lock bit of the addressed region (1 = unlocked) |
| status_byte | output | 8 | Lock status byte, lock bit on bit 6 |

## Verification
The bench drives the first and last word of every region in both layouts at once. An off-by-one comparison bound, or a mirroring that swaps the two parameter regions, shows up there as a wrong index, base or size. It locks a region, then drives power-down and erase attempts under normal protection before reading the bit back. A design that clears locks on power-down, or lets a refused erase through, returns bit 6 high where the bench expects 0. It also issues lock-set and erase together, under every reset level. A design with the priority reversed leaves the region locked, and one that grants under the unused reset code changes a bit it must not touch.

// File: rtl/bb_sector_pkg.sv
// Package: shared reset-level encoding and the region layout arithmetic.
// Assumes the layout is boot, two parameter, one mid and N big regions.
package bb_sector_pkg;

    // Encoding of the reset / power-down pin level
    typedef enum logic [1:0] {
        RP_DOWN     = 2'b00,
        RP_NORMAL   = 2'b01,
        RP_OVERRIDE = 2'b10,
        RP_UNUSED   = 2'b11
    } rp_level_e;

    // Length in words of region i; top-boot mirrors the bottom order
    function automatic int unsigned region_words(
        input int unsigned i,
        input int unsigned n_blk,
        input bit          top,
        input int unsigned boot_w,
        input int unsigned param_w,
        input int unsigned mid_w,
        input int unsigned big_w
    );
        int unsigned k;
        k = top ? (n_blk - 1 - i) : i;
        if (k == 0)       return boot_w;
        else if (k <= 2)  return param_w;
        else if (k == 3)  return mid_w;
        else              return big_w;
    endfunction

    // First word of region i: sum of the lengths of all regions below it
    function automatic int unsigned region_base(
        input int unsigned i,
        input int unsigned n_blk,
        input bit          top,
        input int unsigned boot_w,
        input int unsigned param_w,
        input int unsigned mid_w,
        input int unsigned big_w
    );
        int unsigned acc;
        acc = 0;
        for (int unsigned j = 0; j < i; j++)
            acc += region_words(j, n_blk, top, boot_w, param_w, mid_w, big_w);
        return acc;
    endfunction

endpackage

// File: rtl/bb_region_decode.sv
// Region decoder: compares the address against every region's bounds in
// parallel and returns index, base and length of the hit.
// Assumes the regions tile the address space exactly (one hit per address).
module bb_region_decode
    import bb_sector_pkg::*;
#(
    parameter int unsigned ADDR_W      = 19,
    parameter bit          TOP_BOOT    = 1'b0,
    parameter int unsigned BOOT_WORDS  = 8192,
    parameter int unsigned PARAM_WORDS = 4096,
    parameter int unsigned MID_WORDS   = 16384,
    parameter int unsigned BIG_WORDS   = 32768,
    parameter int unsigned NUM_BLK     = 19,
    parameter int unsigned IDX_W       = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] words
);

    localparam int unsigned SPACE = 1 << ADDR_W;

    logic [NUM_BLK-1:0] hit;
    logic [ADDR_W-1:0]  base_tab  [NUM_BLK];
    logic [ADDR_W-1:0]  words_tab [NUM_BLK];

    for (genvar gi = 0; gi < NUM_BLK; gi++) begin : g_region
        localparam int unsigned LO = region_base(gi, NUM_BLK, TOP_BOOT,
            BOOT_WORDS, PARAM_WORDS, MID_WORDS, BIG_WORDS);
        localparam int unsigned SZ = region_words(gi, NUM_BLK, TOP_BOOT,
            BOOT_WORDS, PARAM_WORDS, MID_WORDS, BIG_WORDS);
        localparam int unsigned HI = LO + SZ;

        logic lo_ok;
        logic hi_ok;

        assign base_tab[gi]  = ADDR_W'(LO);
        assign words_tab[gi] = ADDR_W'(SZ);

        // Lower bound test, dropped for the region starting at zero
        if (LO == 0) begin : g_lo_free
            assign lo_ok = 1'b1;
        end else begin : g_lo_cmp
            assign lo_ok = ({1'b0, addr} >= (ADDR_W+1)'(LO));
        end

        // Upper bound test, dropped for the region ending at the top
        if (HI >= SPACE) begin : g_hi_free
            assign hi_ok = 1'b1;
        end else begin : g_hi_cmp
            assign hi_ok = ({1'b0, addr} < (ADDR_W+1)'(HI));
        end

        assign hit[gi] = lo_ok & hi_ok;
    end

    // Encode the hit vector and select that region's base and length
    always_comb begin
        idx = '0;
        for (int i = NUM_BLK - 1; i >= 0; i--) begin
            if (hit[i]) idx = IDX_W'(i);
        end
        base  = base_tab[idx];
        words = words_tab[idx];
    end

endmodule

// File: rtl/bb_lock_bank.sv
// Lock bank: one flip-flop per region, 1 = unlocked. Clear and set strobes
// act only on the addressed region; the clear (unlock) strobe wins.
// Assumes the strobes arrive already qualified by the protection decision.
module bb_lock_bank #(
    parameter int unsigned NUM_BLK = 19,
    parameter int unsigned IDX_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             lock_en,
    input  logic             unlock_en,
    output logic             lock_at
);

    logic [NUM_BLK-1:0] lock_q;

    for (genvar gi = 0; gi < NUM_BLK; gi++) begin : g_bit
        logic sel;
        assign sel = (idx == IDX_W'(gi));

        // Update one region's lock bit; reset leaves it unlocked
        always_ff @(posedge clk) begin
            if (!rst_n)                 lock_q[gi] <= 1'b1;
            else if (unlock_en && sel)  lock_q[gi] <= 1'b1;
            else if (lock_en && sel)    lock_q[gi] <= 1'b0;
        end
    end

    // Return the addressed region's bit
    always_comb begin
        lock_at = 1'b1;
        for (int i = 0; i < NUM_BLK; i++) begin
            if (idx == IDX_W'(i)) lock_at = lock_q[i];
        end
    end

endmodule

// File: rtl/bb_protect_arb.sv
// Protection arbiter: grants modification from the reset level, the
// write-protect pin and the addressed lock bit. Purely combinational.
// Assumes the unused reset code must be treated as the safe (refuse) case.
module bb_protect_arb
    import bb_sector_pkg::*;
(
    input  logic [1:0] rp_level,
    input  logic       wp_pin,
    input  logic       lock_at,
    output logic       modify_ok
);

    // Decide the grant for the current reset level
    always_comb begin
        unique case (rp_level)
            RP_OVERRIDE: modify_ok = 1'b1;
            RP_NORMAL:   modify_ok = wp_pin | lock_at;
            default:     modify_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/bb_sector_guard.sv
// Top: region decoder, lock bank and protection arbiter for a boot-block
// flash array. Outputs follow the address combinationally; lock changes
// land on the next clock edge. Assumes the controller holds the address
// steady while a request is raised.
module bb_sector_guard
    import bb_sector_pkg::*;
#(
    parameter bit          TOP_BOOT    = 1'b0,
    parameter int unsigned ADDR_W      = 19,
    parameter int unsigned BOOT_WORDS  = 8192,
    parameter int unsigned PARAM_WORDS = 4096,
    parameter int unsigned MID_WORDS   = 16384,
    parameter int unsigned BIG_WORDS   = 32768,
    parameter int unsigned STAT_BIT    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [1:0]        rp_level,
    input  logic              wp_pin,
    input  logic              lock_set_req,
    input  logic              erase_req,
    output logic [4:0]        blk_index,
    output logic [ADDR_W-1:0] blk_base,
    output logic [ADDR_W-1:0] blk_size,
    output logic              modify_ok,
    output logic              lock_bit,
    output logic [7:0]        status_byte
);

    localparam int unsigned SMALL_SUM = BOOT_WORDS + 2 * PARAM_WORDS + MID_WORDS;
    localparam int unsigned NUM_BIG   = ((1 << ADDR_W) - SMALL_SUM) / BIG_WORDS;
    localparam int unsigned NUM_BLK   = 4 + NUM_BIG;
    localparam int unsigned IDX_W     = 5;

    logic lock_en;
    logic unlock_en;

    bb_region_decode #(
        .ADDR_W     (ADDR_W),
        .TOP_BOOT   (TOP_BOOT),
        .BOOT_WORDS (BOOT_WORDS),
        .PARAM_WORDS(PARAM_WORDS),
        .MID_WORDS  (MID_WORDS),
        .BIG_WORDS  (BIG_WORDS),
        .NUM_BLK    (NUM_BLK),
        .IDX_W      (IDX_W)
    ) u_dec (
        .addr (word_addr),
        .idx  (blk_index),
        .base (blk_base),
        .words(blk_size)
    );

    bb_lock_bank #(
        .NUM_BLK(NUM_BLK),
        .IDX_W  (IDX_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (blk_index),
        .lock_en  (lock_en),
        .unlock_en(unlock_en),
        .lock_at  (lock_bit)
    );

    bb_protect_arb u_arb (
        .rp_level (rp_level),
        .wp_pin   (wp_pin),
        .lock_at  (lock_bit),
        .modify_ok(modify_ok)
    );

    // Qualify requests by the grant; erase outranks lock-set
    always_comb begin
        unlock_en = erase_req & modify_ok;
        lock_en   = lock_set_req & modify_ok & ~erase_req;
    end

    // Place the lock bit in its status position, other bits zero
    always_comb begin
        status_byte           = '0;
        status_byte[STAT_BIT] = lock_bit;
    end

endmodule

// File: rtl/bb_sector_guard_chk.sv
// Checker: temporal properties of the sector guard, bound to every instance.
module bb_sector_guard_chk #(
    parameter int unsigned ADDR_W  = 19,
    parameter int unsigned NUM_BLK = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] word_addr,
    input logic [1:0]        rp_level,
    input logic              wp_pin,
    input logic              lock_set_req,
    input logic              erase_req,
    input logic [4:0]        blk_index,
    input logic [ADDR_W-1:0] blk_base,
    input logic [ADDR_W-1:0] blk_size,
    input logic              modify_ok,
    input logic              lock_bit,
    input logic [7:0]        status_byte
);

    // R1 R2
    region_contains_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_index < 5'(NUM_BLK)) && (word_addr >= blk_base) &&
        ((word_addr - blk_base) < blk_size));

    // R4
    pwrdn_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_level == 2'b00 || rp_level == 2'b11) |-> !modify_ok);

    // R5
    override_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_level == 2'b10) |-> modify_ok);

    // R6
    locked_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_level == 2'b01 && !wp_pin && !lock_bit) |-> !modify_ok);

    // R6
    normal_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_level == 2'b01 && (wp_pin || lock_bit)) |-> modify_ok);

    // R7
    lock_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_set_req && modify_ok && !erase_req) |=>
        ($stable(word_addr) -> !lock_bit));

    // R7 R8
    refused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lock_set_req || erase_req) && !modify_ok) |=>
        ($stable(word_addr) -> $stable(lock_bit)));

    // R8
    erase_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && modify_ok) |=> ($stable(word_addr) -> lock_bit));

    // R9
    status_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(status_byte) <= 1) && (status_byte[6] == lock_bit));

endmodule

bind bb_sector_guard bb_sector_guard_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_addr   (word_addr),
    .rp_level    (rp_level),
    .wp_pin      (wp_pin),
    .lock_set_req(lock_set_req),
    .erase_req   (erase_req),
    .blk_index   (blk_index),
    .blk_base    (blk_base),
    .blk_size    (blk_size),
    .modify_ok   (modify_ok),
    .lock_bit    (lock_bit),
    .status_byte (status_byte)
);

// File: tb/sim_bb_sector_guard.sv
module sim_bb_sector_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] word_addr = '0;
    logic [1:0]  rp_level = 2'b01;
    logic        wp_pin = 1'b0;
    logic        lock_set_req = 1'b0;
    logic        erase_req = 1'b0;

    logic [4:0]  idx_b, idx_t;
    logic [18:0] base_b, base_t, size_b, size_t;
    logic        ok_b, ok_t, lk_b, lk_t;
    logic [7:0]  st_b, st_t;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;
    bit          mdl_b [19];
    bit          mdl_t [19];
    string       st_tag = "R9";

    always #2 clk = ~clk;

    bb_sector_guard #(.TOP_BOOT(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .word_addr(word_addr), .rp_level(rp_level),
        .wp_pin(wp_pin), .lock_set_req(lock_set_req), .erase_req(erase_req),
        .blk_index(idx_b), .blk_base(base_b), .blk_size(size_b),
        .modify_ok(ok_b), .lock_bit(lk_b), .status_byte(st_b));

    bb_sector_guard #(.TOP_BOOT(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .word_addr(word_addr), .rp_level(rp_level),
        .wp_pin(wp_pin), .lock_set_req(lock_set_req), .erase_req(erase_req),
        .blk_index(idx_t), .blk_base(base_t), .blk_size(size_t),
        .modify_ok(ok_t), .lock_bit(lk_t), .status_byte(st_t));

    // Expected layouts
    function automatic int unsigned bot_idx(input int unsigned a);
        if (a < 'h2000) return 0;
        if (a < 'h3000) return 1;
        if (a < 'h4000) return 2;
        if (a < 'h8000) return 3;
        return 3 + (a >> 15);
    endfunction
    function automatic int unsigned bot_base(input int unsigned i);
        case (i)
            0: return 0;  1: return 'h2000;  2: return 'h3000;  3: return 'h4000;
            default: return (i - 3) * 'h8000;
        endcase
    endfunction
    function automatic int unsigned bot_size(input int unsigned i);
        case (i)
            0: return 8192;  1, 2: return 4096;  3: return 16384;
            default: return 32768;
        endcase
    endfunction
    function automatic int unsigned top_idx(input int unsigned a);
        if (a < 'h78000) return a >> 15;
        if (a < 'h7C000) return 15;
        if (a < 'h7D000) return 16;
        if (a < 'h7E000) return 17;
        return 18;
    endfunction
    function automatic int unsigned top_base(input int unsigned i);
        if (i <= 14) return i * 'h8000;
        case (i)
            15: return 'h78000;  16: return 'h7C000;  17: return 'h7D000;
            default: return 'h7E000;
        endcase
    endfunction
    function automatic int unsigned top_size(input int unsigned i);
        if (i <= 14) return 32768;
        case (i)
            15: return 16384;  16, 17: return 4096;
            default: return 8192;
        endcase
    endfunction
    function automatic bit exp_ok(input logic [1:0] rp, input bit wp, input bit lk);
        case (rp)
            2'b10:   return 1'b1;
            2'b01:   return wp | lk;
            default: return 1'b0;
        endcase
    endfunction
    function automatic string ok_tag(input logic [1:0] rp);
        if (rp == 2'b10) return "R5";
        if (rp == 2'b01) return "R6";
        return "R4";
    endfunction

    task automatic chk(input string tag, input string what,
                       input int unsigned got, input int unsigned exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h (addr 0x%0h)",
                     tag, what, got, exp, word_addr);
        end
    endtask

    // Apply one cycle of stimulus, check outputs, then advance the model
    task automatic step(input logic [18:0] a, input logic [1:0] rp,
                        input bit wp, input bit ls, input bit er);
        int unsigned ib, it;
        bit okb, okt;
        @(negedge clk);
        word_addr = a;  rp_level = rp;  wp_pin = wp;
        lock_set_req = ls;  erase_req = er;
        #1;
        ib = bot_idx(a);
        it = top_idx(a);
        okb = exp_ok(rp, wp, mdl_b[ib]);
        okt = exp_ok(rp, wp, mdl_t[it]);
        chk("R1", "bottom index", idx_b, ib);
        chk("R1", "bottom base", base_b, bot_base(ib));
        chk("R1", "bottom size", size_b, bot_size(ib));
        chk("R2", "top index", idx_t, it);
        chk("R2", "top base", base_t, top_base(it));
        chk("R2", "top size", size_t, top_size(it));
        chk(ok_tag(rp), "bottom grant", ok_b, okb);
        chk(ok_tag(rp), "top grant", ok_t, okt);
        chk(st_tag, "bottom status", st_b, mdl_b[ib] ? 8'h40 : 8'h00);
        chk(st_tag, "top status", st_t, mdl_t[it] ? 8'h40 : 8'h00);
        if (er && okb)      mdl_b[ib] = 1'b1;
        else if (ls && okb) mdl_b[ib] = 1'b0;
        if (er && okt)      mdl_t[it] = 1'b1;
        else if (ls && okt) mdl_t[it] = 1'b0;
    endtask

    task automatic clear_model();
        for (int i = 0; i < 19; i++) begin
            mdl_b[i] = 1'b1;
            mdl_t[i] = 1'b1;
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned edges [38];
        int unsigned seed;
        void'($urandom(32'h5EC7));
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3: every region unlocked out of reset
        st_tag = "R3";
        for (int i = 0; i < 19; i++) step(19'(bot_base(i)), 2'b01, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 19; i++) step(19'(top_base(i)), 2'b01, 1'b0, 1'b0, 1'b0);

        // R1 R2: first and last word of every region, both layouts
        st_tag = "R9";
        for (int i = 0; i < 19; i++) begin
            edges[2*i]     = bot_base(i);
            edges[2*i + 1] = bot_base(i) + bot_size(i) - 1;
        end
        foreach (edges[k]) step(19'(edges[k]), 2'b01, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 19; i++) begin
            step(19'(top_base(i)), 2'b01, 1'b1, 1'b0, 1'b0);
            step(19'(top_base(i) + top_size(i) - 1), 2'b01, 1'b1, 1'b0, 1'b0);
        end

        // R7: lock the boot region, then a refused lock elsewhere under power-down
        st_tag = "R7";
        step(19'h00010, 2'b01, 1'b0, 1'b1, 1'b0);
        step(19'h00010, 2'b01, 1'b0, 1'b0, 1'b0);
        step(19'h7E100, 2'b00, 1'b1, 1'b1, 1'b0);
        step(19'h7E100, 2'b01, 1'b0, 1'b0, 1'b0);

        // R3: power-down level does not unlock; R4 refuses erase there
        st_tag = "R3";
        repeat (3) step(19'h00010, 2'b00, 1'b1, 1'b0, 1'b1);
        step(19'h00010, 2'b01, 1'b0, 1'b0, 1'b0);

        // R8: erase refused while locked under normal level, then granted by wp
        st_tag = "R8";
        step(19'h01FFF, 2'b01, 1'b0, 1'b0, 1'b1);
        step(19'h01FFF, 2'b01, 1'b0, 1'b0, 1'b0);
        step(19'h01FFF, 2'b01, 1'b1, 1'b0, 1'b1);
        step(19'h01FFF, 2'b01, 1'b0, 1'b0, 1'b0);
        // R8: erase wins over a simultaneous lock-set
        step(19'h03000, 2'b10, 1'b0, 1'b1, 1'b1);
        step(19'h03000, 2'b01, 1'b0, 1'b0, 1'b0);
        // R4: unused reset code refuses a lock
        step(19'h03000, 2'b11, 1'b1, 1'b1, 1'b0);
        step(19'h03000, 2'b01, 1'b0, 1'b0, 1'b0);

        // Random mix, with region edges favoured
        st_tag = "R9";
        for (int n = 0; n < 1500; n++) begin
            logic [18:0] a;
            logic [1:0]  rp;
            seed = $urandom;
            if (seed[1:0] == 2'b00) a = 19'(edges[$urandom % 38]);
            else if (seed[3:2] == 2'b00) a = 19'($urandom % 'h4000) | 19'h7C000;
            else a = 19'($urandom);
            rp = ($urandom % 4 == 0) ? 2'($urandom) : 2'b01;
            step(a, rp, ($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 6) == 0);
            if (n == 900) begin
                // R3: mid-run reset unlocks everything
                @(negedge clk);
                rst_n = 1'b0;  lock_set_req = 1'b0;  erase_req = 1'b0;
                @(negedge clk);
                rst_n = 1'b1;
                clear_model();
                st_tag = "R3";
                for (int i = 0; i < 19; i++) step(19'(bot_base(i)), 2'b01, 1'b0, 1'b0, 1'b0);
                st_tag = "R9";
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule